// File: doc/BRIEF.md
# Two-Wire Controller Command-Word Register Bridge

This block gives a host access to the small 8-bit register file of a two-wire serial controller through a single 64-bit command/status word. The host writes the word with its top bit set. That write carries an opcode, a read/write flag, a 3-bit internal address and a data byte. The bridge then runs exactly one internal operation. The operation is either a read or write of an internal register, or a load of the bus clock high-period parameter.

While the operation runs, the top bit of the word reads back as 1. When the operation finishes, the bridge clears that bit. A read operation leaves its result in the low byte of the word.

The internal register file is a simple model. It holds:
- a data register and a control register, both read/write;
- a write-only clock-control register, whose address returns a status code when read;
- a soft-reset address.

The reserved fields of the word are decoded nowhere and have no function. The clock settings are driven out as ports so that the rest of the controller can use them.

Top module: `twi_cmd_bridge`

## Requirements
- R1: After reset, `host_rdata` is all zero, and both `hi_period` and `clk_ctl` are zero.
- R2: A write with `host_we`=1 and bit 63 of `host_wdata` set, made while bit 63 of `host_rdata` is 0, starts an operation. Bit 63 of `host_rdata` reads 1 after that clock edge.
- R3: Bit 63 of `host_rdata` stays 1 for exactly 4 clock cycles after the accepting edge and then returns to 0.
- R4: Opcode 6 (bits 60:57) is a register access. Bit 56 = 0 writes `host_wdata[7:0]` to the internal address in bits 34:32; bit 56 = 1 reads it. Address 1 is the data register and address 2 is the control register; both hold the last byte written.
- R5: With opcode 6, a write to address 3 sets `clk_ctl`. A read of address 3 returns the status code 0xF8 (idle).
- R6: With opcode 6, a write to address 7 clears the data and control registers to 0 and leaves status at 0xF8. `clk_ctl` and `hi_period` are unchanged.
- R7: Opcode 4 loads `hi_period` from `host_wdata[6:0]`. The address and read flag are ignored, and no internal register changes.
- R8: A host write made while bit 63 of `host_rdata` is 1 is ignored. The running operation finishes unchanged and no second operation follows.
- R9: A host write with bit 63 clear starts nothing and changes no register.
- R10: The reserved bits (62, 61, 55, 54:52, 51:50, 49:40, 39:35) have no effect on any operation.
- R11: `host_rdata` bits 62:8 always read 0. Bits 7:0 hold the last register read result and change only when a read operation completes.
- R12: Any opcode other than 4 or 6 completes with the same timing but changes no register and no output byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Busy bit (63) and last read byte (7:0) |
| hi_period | output | HP_W (7) | Clock high-period parameter |
| clk_ctl | output | 8 | Clock-control divider byte |

## Verification
The bench goes after the following corner cases, and what each one catches:
- A host write landing while an operation is still busy. A bridge that latched it would corrupt the data register or produce an extra completion.
- A write whose top bit is clear. A design that ignored the valid bit would start a phantom operation.
- A clock-parameter load that also carries a register address and the read flag. A decoder that did not gate on the opcode would overwrite a register or the returned byte.
- A soft reset. A model that cleared too much would zero the clock-control byte.
- A command with every reserved bit set. This exposes any field-overlap mistake.
- Every completion is timed to the cycle. This catches an off-by-one latency counter.

// File: rtl/twi_br_pkg.sv
package twi_br_pkg;
  localparam int CMD_W  = 64;
  localparam int BYTE_W = 8;
  localparam int V_BIT  = 63;
  localparam int RD_BIT = 56;
  localparam int OP_LO  = 57;
  localparam int OP_HI  = 60;
  localparam int IA_LO  = 32;
  localparam int IA_HI  = 34;

  localparam logic [3:0] OP_REG = 4'd6;
  localparam logic [3:0] OP_CLK = 4'd4;

  localparam logic [2:0] IA_DATA = 3'd1;
  localparam logic [2:0] IA_CTL  = 3'd2;
  localparam logic [2:0] IA_CLK  = 3'd3;
  localparam logic [2:0] IA_RST  = 3'd7;

  localparam logic [BYTE_W-1:0] STAT_IDLE = 8'hF8;

  typedef struct packed {
    logic              vld;
    logic [3:0]        op;
    logic              rd;
    logic [2:0]        ia;
    logic [BYTE_W-1:0] dat;
  } cmd_t;
endpackage

// File: rtl/twi_cmd_decode.sv
module twi_cmd_decode
  import twi_br_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output cmd_t             cmd
);
  always_comb begin
    cmd.vld = word[V_BIT];
    cmd.op  = word[OP_HI:OP_LO];
    cmd.rd  = word[RD_BIT];
    cmd.ia  = word[IA_HI:IA_LO];
    cmd.dat = word[BYTE_W-1:0];
  end
endmodule

// File: rtl/twi_op_seq.sv
module twi_op_seq #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = busy && (cnt == LAST);

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST));
  assert_done_ends_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
endmodule

// File: rtl/twi_reg_model.sv
module twi_reg_model
  import twi_br_pkg::*;
#(
  parameter int HP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              hp_we,
  input  logic [HP_W-1:0]   hp_wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [HP_W-1:0]   hp_q,
  output logic [BYTE_W-1:0] div_q
);
  logic [BYTE_W-1:0] data_r;
  logic [BYTE_W-1:0] ctl_r;
  logic              srst;

  assign srst = we && (addr == IA_RST);

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      data_r <= '0;
      ctl_r  <= '0;
    end else if (we) begin
      if (addr == IA_DATA) data_r <= wdata;
      if (addr == IA_CTL)  ctl_r  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      hp_q  <= '0;
    end else begin
      if (we && addr == IA_CLK) div_q <= wdata;
      if (hp_we)                hp_q  <= hp_wdata;
    end
  end

  always_comb begin
    case (addr)
      IA_DATA: rdata = data_r;
      IA_CTL:  rdata = ctl_r;
      IA_CLK:  rdata = STAT_IDLE;
      default: rdata = '0;
    endcase
  end

  assert_srst_clears_R6: assert property (@(posedge clk) disable iff (rst)
    srst |=> (data_r == '0) && (ctl_r == '0));
  assert_srst_keeps_clk_R6: assert property (@(posedge clk) disable iff (rst)
    srst |=> $stable(div_q) && $stable(hp_q));
endmodule

// File: rtl/twi_cmd_bridge.sv
module twi_cmd_bridge
  import twi_br_pkg::*;
#(
  parameter int LAT  = 4,
  parameter int HP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [CMD_W-1:0]  host_wdata,
  output logic [CMD_W-1:0]  host_rdata,
  output logic [HP_W-1:0]   hi_period,
  output logic [BYTE_W-1:0] clk_ctl
);
  localparam int PAD_W = CMD_W - 1 - BYTE_W;

  cmd_t              cmd_in;
  cmd_t              cmd_q;
  logic              busy;
  logic              done;
  logic              start;
  logic              rf_we;
  logic              hp_we;
  logic [BYTE_W-1:0] rf_rdata;
  logic [BYTE_W-1:0] rbyte_q;

  twi_cmd_decode u_dec (
    .word (host_wdata),
    .cmd  (cmd_in)
  );

  assign start = host_we && cmd_in.vld && !busy;

  twi_op_seq #(.LAT(LAT)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (rst)        cmd_q <= '0;
    else if (start) cmd_q <= cmd_in;
  end

  assign rf_we = done && (cmd_q.op == OP_REG) && !cmd_q.rd;
  assign hp_we = done && (cmd_q.op == OP_CLK);

  twi_reg_model #(.HP_W(HP_W)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (rf_we),
    .addr     (cmd_q.ia),
    .wdata    (cmd_q.dat),
    .hp_we    (hp_we),
    .hp_wdata (cmd_q.dat[HP_W-1:0]),
    .rdata    (rf_rdata),
    .hp_q     (hi_period),
    .div_q    (clk_ctl)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rbyte_q <= '0;
    else if (done && (cmd_q.op == OP_REG) && cmd_q.rd)
      rbyte_q <= rf_rdata;
  end

  assign host_rdata = {busy, {PAD_W{1'b0}}, rbyte_q};

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_wdata[V_BIT] && !host_rdata[V_BIT]) |=> host_rdata[V_BIT]);
  assert_no_start_R9: assert property (@(posedge clk) disable iff (rst)
    (!host_rdata[V_BIT] && !(host_we && host_wdata[V_BIT])) |=> !host_rdata[V_BIT]);
  assert_cmd_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(cmd_q));
  assert_pad_zero_R11: assert property (@(posedge clk) disable iff (rst)
    host_rdata[CMD_W-2:BYTE_W] == '0);
  assert_byte_moves_on_done_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(host_rdata[BYTE_W-1:0]) |-> $fell(host_rdata[V_BIT]));
endmodule

// File: tb/sim_twi_cmd_bridge.sv
module sim_twi_cmd_bridge;
  localparam int CLK_P = 10;
  localparam int LAT   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic [6:0]  hi_period;
  logic [7:0]  clk_ctl;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_b = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       prev_v = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  twi_cmd_bridge u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .hi_period(hi_period), .clk_ctl(clk_ctl)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] op, input logic rd,
                                     input logic [2:0] ia, input logic [7:0] d);
    mk = '0;
    mk[63] = 1'b1; mk[60:57] = op; mk[56] = rd; mk[34:32] = ia; mk[7:0] = d;
  endfunction

  // monitor: compares completions against the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (host_rdata[62:8] != '0) begin
        errors++;
        $display("FAIL R11: pad bits got %h expected 0", host_rdata[62:8]);
      end
      if (prev_v && !host_rdata[63]) begin
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8: unexpected completion got %h expected none", host_rdata);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(t, {56'h0, host_rdata[7:0]}, {56'h0, e});
        end
      end
      prev_v = host_rdata[63];
    end
  end

  // drive one command; optional second write during busy
  task automatic issue(input logic [63:0] w, input logic rd_op, input logic [7:0] rd_exp,
                       input string tag, input logic intrude = 1'b0,
                       input logic [63:0] w2 = '0);
    int n;
    if (rd_op) last_b = rd_exp;
    exp_q.push_back(last_b);
    tag_q.push_back(tag);
    @(negedge clk);
    host_wdata = w; host_we = 1'b1;
    @(negedge clk);
    n = 1;
    chk("R2", {63'h0, host_rdata[63]}, 64'h1);
    if (intrude) host_wdata = w2; else host_we = 1'b0;
    @(negedge clk);
    n++;
    host_we = 1'b0;
    while (host_rdata[63] && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk("R3", 64'(n - 1), 64'(LAT));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", host_rdata, 64'h0);
    chk("R1", {57'h0, hi_period}, 64'h0);
    chk("R1", {56'h0, clk_ctl}, 64'h0);

    // R4 data and control registers
    issue(mk(4'd6, 1'b0, 3'd1, 8'h5A), 1'b0, 8'h00, "R4");
    issue(mk(4'd6, 1'b1, 3'd1, 8'h00), 1'b1, 8'h5A, "R4");
    issue(mk(4'd6, 1'b0, 3'd2, 8'h44), 1'b0, 8'h00, "R4");
    issue(mk(4'd6, 1'b1, 3'd2, 8'hEE), 1'b1, 8'h44, "R4");

    // R5 clock control write / status read
    issue(mk(4'd6, 1'b0, 3'd3, 8'h2B), 1'b0, 8'h00, "R5");
    chk("R5", {56'h0, clk_ctl}, 64'h2B);
    issue(mk(4'd6, 1'b1, 3'd3, 8'h00), 1'b1, 8'hF8, "R5");

    // R7 clock high-period load, address and read flag ignored
    issue(mk(4'd4, 1'b1, 3'd1, 8'h98), 1'b0, 8'h00, "R7");
    chk("R7", {57'h0, hi_period}, 64'h18);
    chk("R7", {56'h0, host_rdata[7:0]}, 64'hF8);
    issue(mk(4'd6, 1'b1, 3'd1, 8'h00), 1'b1, 8'h5A, "R7");

    // R10 reserved bits all set
    w = mk(4'd6, 1'b0, 3'd1, 8'h33);
    w[62] = 1; w[61] = 1; w[55] = 1; w[54:52] = '1; w[51:50] = '1; w[49:40] = '1; w[39:35] = '1;
    issue(w, 1'b0, 8'h00, "R10");
    issue(mk(4'd6, 1'b1, 3'd1, 8'h00), 1'b1, 8'h33, "R10");

    // R9 write without the valid bit
    @(negedge clk);
    w = mk(4'd6, 1'b0, 3'd1, 8'h77); w[63] = 1'b0;
    host_wdata = w; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    chk("R9", {63'h0, host_rdata[63]}, 64'h0);
    repeat (6) @(negedge clk);
    issue(mk(4'd6, 1'b1, 3'd1, 8'h00), 1'b1, 8'h33, "R9");

    // R8 write during busy ignored
    issue(mk(4'd6, 1'b0, 3'd1, 8'hA1), 1'b0, 8'h00, "R8", 1'b1, mk(4'd6, 1'b0, 3'd1, 8'h1F));
    issue(mk(4'd6, 1'b1, 3'd1, 8'h00), 1'b1, 8'hA1, "R8");

    // R12 unknown opcode
    issue(mk(4'd3, 1'b1, 3'd2, 8'h00), 1'b0, 8'h00, "R12");
    issue(mk(4'd9, 1'b0, 3'd1, 8'h66), 1'b0, 8'h00, "R12");
    issue(mk(4'd6, 1'b1, 3'd1, 8'h00), 1'b1, 8'hA1, "R12");

    // R6 soft reset
    issue(mk(4'd6, 1'b0, 3'd7, 8'hFF), 1'b0, 8'h00, "R6");
    issue(mk(4'd6, 1'b1, 3'd1, 8'h00), 1'b1, 8'h00, "R6");
    issue(mk(4'd6, 1'b1, 3'd2, 8'h00), 1'b1, 8'h00, "R6");
    issue(mk(4'd6, 1'b1, 3'd3, 8'h00), 1'b1, 8'hF8, "R6");
    chk("R6", {56'h0, clk_ctl}, 64'h2B);
    chk("R6", {57'h0, hi_period}, 64'h18);

    // R11 byte unchanged by a write
    issue(mk(4'd6, 1'b0, 3'd2, 8'h0C), 1'b0, 8'h00, "R11");
    chk("R11", {56'h0, host_rdata[7:0]}, 64'hF8);

    repeat (4) @(negedge clk);
    chk("R8", 64'(exp_q.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule